// File: doc/BRIEF.md
# Secure debug authentication controller

This block decides, separately for every core of a small cluster, whether halting (invasive) debug and trace (non-invasive) debug may be used on that core right now. The answer depends on the core's current security world (secure or normal) and its privilege level (privileged or user). Each core has its own set of enable inputs: a global halting enable, a global trace enable, a secure-privileged halting enable and a secure-privileged trace enable. The secure-user permissions come from a small configuration register per core that only secure privileged software may write.

The permissions are registered and appear one clock after the inputs that produce them. A write attempt from normal world or from user mode changes nothing and raises a one-cycle error pulse. A parameter picks a legacy arrangement, in which the global halting enable also gates trace and the global trace enable input is not used. Any core's register can be read back through a combinational read port.

Top module: `sdbg_auth`

## Requirements
- R1: A core that is secure and privileged gets halting permission only when both its secure-privileged halting enable and its global halting enable are high.
- R2: A core that is secure and privileged gets trace permission only when both its secure-privileged trace enable and its effective global trace enable are high.
- R3: A core that is secure and in user mode gets halting permission from bit 0 of its configuration register ANDed with its global halting enable. It gets trace permission from bit 1 of that register ANDed with its effective global trace enable.
- R4: A configuration write is accepted only when the write is valid and the access is both secure and privileged. The write targets the register selected by `cfg_wr_core`, and any other write leaves every register unchanged. `cfg_rd_data` shows the contents of the register selected by `cfg_rd_core` in the same cycle.
- R5: While a core's global halting enable is low, that core gets no halting permission in either world or at either privilege level.
- R6: With `LEGACY_TRACE`=1 the effective global trace enable is the global halting enable, and `glb_trc_en` has no effect. With `LEGACY_TRACE`=0 it is `glb_trc_en`.
- R7: In normal world, halting permission equals the global halting enable and trace permission equals the effective global trace enable, whatever the privilege level. Full normal-world debug is therefore available while all secure enables and configuration bits are zero.
- R8: A valid write that is not both secure and privileged raises `cfg_err` for exactly the next cycle. `cfg_err` is low in every other cycle.
- R9: Each core's permissions depend only on that core's own inputs and configuration register.
- R10: During reset every configuration register is zero, and `inv_ok`, `trc_ok` and `cfg_err` are low. After reset each permission output reflects the inputs and register contents of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_secure | input | NUM_CORES | Per core: 1 when the core runs in the secure world |
| core_priv | input | NUM_CORES | Per core: 1 when the core runs privileged |
| glb_inv_en | input | NUM_CORES | Per core global halting-debug enable |
| glb_trc_en | input | NUM_CORES | Per core global trace enable (not used when LEGACY_TRACE=1) |
| sp_inv_en | input | NUM_CORES | Per core secure-privileged halting enable |
| sp_trc_en | input | NUM_CORES | Per core secure-privileged trace enable |
| cfg_wr_valid | input | 1 | Configuration write request |
| cfg_wr_core | input | IDX_W | Core whose register is written |
| cfg_wr_data | input | 2 | Bit 0 secure-user halting, bit 1 secure-user trace |
| cfg_wr_secure | input | 1 | Write issued from the secure world |
| cfg_wr_priv | input | 1 | Write issued in privileged mode |
| cfg_rd_core | input | IDX_W | Core whose register is read back |
| cfg_rd_data | output | 2 | Contents of the selected register |
| cfg_err | output | 1 | One-cycle pulse after a rejected write |
| inv_ok | output | NUM_CORES | Registered halting permission per core |
| trc_ok | output | NUM_CORES | Registered trace permission per core |

## Verification
The assertions assume that every input is synchronous to `clk` and holds a defined 0 or 1 at each rising edge. They also assume that the core indices stay below `NUM_CORES`. The bench changes its inputs only one nanosecond after a rising edge and draws the core indices from the valid range. The step-based properties compare outputs with `$past` of inputs, so they also rely on reset lasting at least one edge. The bench holds reset for several cycles before it releases it.

// File: rtl/sdbg_pkg.sv
package sdbg_pkg;

  // Secure-user configuration: bit 0 halting, bit 1 trace
  typedef struct packed {
    logic u_trc;
    logic u_inv;
  } ucfg_t;

  typedef struct packed {
    logic trc;
    logic inv;
  } perm_t;

  // Effective global trace gate for the selected mode
  function automatic logic trace_gate(input logic legacy, input logic g_inv,
                                      input logic g_trc);
    return legacy ? g_inv : g_trc;
  endfunction

  // Four-way permission decision for one core
  function automatic perm_t grant(input logic legacy, input logic secure,
                                  input logic priv, input logic g_inv,
                                  input logic g_trc, input logic s_inv,
                                  input logic s_trc, input ucfg_t ucfg);
    perm_t p;
    logic  tg;
    tg = trace_gate(legacy, g_inv, g_trc);
    if (!secure) begin
      p.inv = g_inv;
      p.trc = tg;
    end else if (priv) begin
      p.inv = g_inv & s_inv;
      p.trc = tg & s_trc;
    end else begin
      p.inv = g_inv & ucfg.u_inv;
      p.trc = tg & ucfg.u_trc;
    end
    return p;
  endfunction

endpackage

// File: rtl/sdbg_cfg_bank.sv
module sdbg_cfg_bank
  import sdbg_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  input  logic [IDX_W-1:0]       wr_core,
  input  logic [1:0]             wr_data,
  input  logic                   wr_secure,
  input  logic                   wr_priv,
  input  logic [IDX_W-1:0]       rd_core,
  output logic [1:0]             rd_data,
  output logic                   err_q,
  output logic                   wr_accept,
  output logic                   wr_reject,
  output logic [2*NUM_CORES-1:0] cfg_flat
);

  ucfg_t cfg_q [NUM_CORES];

  assign wr_accept = wr_valid & wr_secure & wr_priv;
  assign wr_reject = wr_valid & ~(wr_secure & wr_priv);

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[i] <= '0;
      end else if (wr_accept && (wr_core == IDX_W'(i))) begin
        cfg_q[i] <= ucfg_t'(wr_data);
      end
    end
    assign cfg_flat[2*i +: 2] = cfg_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= wr_reject;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_CORES; k++) begin
      if (rd_core == IDX_W'(k)) begin
        rd_data = cfg_q[k];
      end
    end
  end

endmodule

// File: rtl/sdbg_core_gate.sv
module sdbg_core_gate
  import sdbg_pkg::*;
#(
  parameter bit LEGACY_TRACE = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  secure,
  input  logic  priv,
  input  logic  g_inv,
  input  logic  g_trc,
  input  logic  s_inv,
  input  logic  s_trc,
  input  ucfg_t ucfg,
  output logic  inv_q,
  output logic  trc_q
);

  perm_t next_p;

  always_comb begin
    next_p = grant(LEGACY_TRACE, secure, priv, g_inv, g_trc, s_inv, s_trc, ucfg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_q <= 1'b0;
      trc_q <= 1'b0;
    end else begin
      inv_q <= next_p.inv;
      trc_q <= next_p.trc;
    end
  end

endmodule

// File: rtl/sdbg_auth.sv
module sdbg_auth
  import sdbg_pkg::*;
#(
  parameter int NUM_CORES    = 4,
  parameter bit LEGACY_TRACE = 1'b0,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] core_secure,
  input  logic [NUM_CORES-1:0] core_priv,
  input  logic [NUM_CORES-1:0] glb_inv_en,
  input  logic [NUM_CORES-1:0] glb_trc_en,
  input  logic [NUM_CORES-1:0] sp_inv_en,
  input  logic [NUM_CORES-1:0] sp_trc_en,
  input  logic                 cfg_wr_valid,
  input  logic [IDX_W-1:0]     cfg_wr_core,
  input  logic [1:0]           cfg_wr_data,
  input  logic                 cfg_wr_secure,
  input  logic                 cfg_wr_priv,
  input  logic [IDX_W-1:0]     cfg_rd_core,
  output logic [1:0]           cfg_rd_data,
  output logic                 cfg_err,
  output logic [NUM_CORES-1:0] inv_ok,
  output logic [NUM_CORES-1:0] trc_ok
);

  // Internal events brought out for the checker
  logic                   wr_accept;
  logic                   wr_reject;
  logic [2*NUM_CORES-1:0] cfg_flat;

  sdbg_cfg_bank #(.NUM_CORES(NUM_CORES)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (cfg_wr_valid),
    .wr_core   (cfg_wr_core),
    .wr_data   (cfg_wr_data),
    .wr_secure (cfg_wr_secure),
    .wr_priv   (cfg_wr_priv),
    .rd_core   (cfg_rd_core),
    .rd_data   (cfg_rd_data),
    .err_q     (cfg_err),
    .wr_accept (wr_accept),
    .wr_reject (wr_reject),
    .cfg_flat  (cfg_flat)
  );

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    sdbg_core_gate #(.LEGACY_TRACE(LEGACY_TRACE)) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .secure (core_secure[i]),
      .priv   (core_priv[i]),
      .g_inv  (glb_inv_en[i]),
      .g_trc  (glb_trc_en[i]),
      .s_inv  (sp_inv_en[i]),
      .s_trc  (sp_trc_en[i]),
      .ucfg   (ucfg_t'(cfg_flat[2*i +: 2])),
      .inv_q  (inv_ok[i]),
      .trc_q  (trc_ok[i])
    );
  end

endmodule

// File: rtl/sdbg_auth_chk.sv
module sdbg_auth_chk #(
  parameter int NUM_CORES    = 4,
  parameter bit LEGACY_TRACE = 1'b0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_CORES-1:0]   core_secure,
  input logic [NUM_CORES-1:0]   core_priv,
  input logic [NUM_CORES-1:0]   glb_inv_en,
  input logic [NUM_CORES-1:0]   sp_inv_en,
  input logic [NUM_CORES-1:0]   sp_trc_en,
  input logic                   cfg_err,
  input logic [NUM_CORES-1:0]   inv_ok,
  input logic [NUM_CORES-1:0]   trc_ok,
  input logic                   wr_reject,
  input logic [2*NUM_CORES-1:0] cfg_flat
);

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_c
    AST_SP_INV_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (core_secure[i] && core_priv[i] && !sp_inv_en[i]) |=> !inv_ok[i]); // R1
    AST_SP_TRC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (core_secure[i] && core_priv[i] && !sp_trc_en[i]) |=> !trc_ok[i]); // R2
    AST_SU_INV_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      (core_secure[i] && !core_priv[i]) |=>
        (inv_ok[i] == ($past(glb_inv_en[i]) && $past(cfg_flat[2*i])))); // R3
    AST_GLB_INV_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_inv_en[i] |=> !inv_ok[i]); // R5
    AST_NRM_INV: assert property (@(posedge clk) disable iff (!rst_n)
      !core_secure[i] |=> (inv_ok[i] == $past(glb_inv_en[i]))); // R7
    if (LEGACY_TRACE) begin : g_leg
      AST_LEGACY_TRC_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_inv_en[i] |=> !trc_ok[i]); // R6
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> (cfg_flat == $past(cfg_flat))); // R4
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> cfg_err); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_reject |=> !cfg_err); // R8

endmodule

bind sdbg_auth sdbg_auth_chk #(
  .NUM_CORES    (NUM_CORES),
  .LEGACY_TRACE (LEGACY_TRACE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .core_secure (core_secure),
  .core_priv   (core_priv),
  .glb_inv_en  (glb_inv_en),
  .sp_inv_en   (sp_inv_en),
  .sp_trc_en   (sp_trc_en),
  .cfg_err     (cfg_err),
  .inv_ok      (inv_ok),
  .trc_ok      (trc_ok),
  .wr_reject   (wr_reject),
  .cfg_flat    (cfg_flat)
);

// File: tb/test_sdbg_auth.sv
`timescale 1ns/1ps
module test_sdbg_auth;

  localparam int NC = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] sec = '0, prv = '0, ginv = '0, gtrc = '0, spi = '0, spt = '0;
  logic          wv = 1'b0, ws = 1'b0, wp = 1'b0;
  logic [IW-1:0] wc = '0, rc = '0;
  logic [1:0]    wd = '0;
  logic [1:0]    rd0, rd1;
  logic          err0, err1;
  logic [NC-1:0] inv0, trc0, inv1, trc1;

  int errors = 0;
  int checks = 0;
  bit started = 1'b0;
  string phase = "R10";

  // reference model state
  logic [1:0]    m_cfg [NC];
  logic [NC-1:0] e_inv, e_trc0, e_trc1;
  logic          e_err;
  string         t_inv [NC];
  string         t_trc [NC];

  always #2 clk = ~clk;  // 250 MHz

  sdbg_auth #(.NUM_CORES(NC), .LEGACY_TRACE(1'b0)) i_sdbg_auth (
    .clk(clk), .rst_n(rst_n), .core_secure(sec), .core_priv(prv),
    .glb_inv_en(ginv), .glb_trc_en(gtrc), .sp_inv_en(spi), .sp_trc_en(spt),
    .cfg_wr_valid(wv), .cfg_wr_core(wc), .cfg_wr_data(wd),
    .cfg_wr_secure(ws), .cfg_wr_priv(wp), .cfg_rd_core(rc),
    .cfg_rd_data(rd0), .cfg_err(err0), .inv_ok(inv0), .trc_ok(trc0));

  sdbg_auth #(.NUM_CORES(NC), .LEGACY_TRACE(1'b1)) i_sdbg_auth_legacy (
    .clk(clk), .rst_n(rst_n), .core_secure(sec), .core_priv(prv),
    .glb_inv_en(ginv), .glb_trc_en(gtrc), .sp_inv_en(spi), .sp_trc_en(spt),
    .cfg_wr_valid(wv), .cfg_wr_core(wc), .cfg_wr_data(wd),
    .cfg_wr_secure(ws), .cfg_wr_priv(wp), .cfg_rd_core(rc),
    .cfg_rd_data(rd1), .cfg_err(err1), .inv_ok(inv1), .trc_ok(trc1));

  // behavioural model, advanced on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NC; k++) m_cfg[k] = 2'b00;
      e_inv = '0; e_trc0 = '0; e_trc1 = '0; e_err = 1'b0;
      for (int k = 0; k < NC; k++) begin t_inv[k] = "R10"; t_trc[k] = "R10"; end
    end else begin
      for (int k = 0; k < NC; k++) begin
        bit gi, gt0, gt1, a, b0, b1;
        gi  = ginv[k];
        gt0 = gtrc[k];   // R6: separate trace gate
        gt1 = ginv[k];   // R6: legacy, halting enable gates trace
        if (!sec[k]) begin
          a = gi; b0 = gt0; b1 = gt1;
          t_inv[k] = gi ? "R7" : "R5"; t_trc[k] = "R7";
        end else if (prv[k]) begin
          a = gi && spi[k]; b0 = gt0 && spt[k]; b1 = gt1 && spt[k];
          t_inv[k] = gi ? "R1" : "R5"; t_trc[k] = "R2";
        end else begin
          a = gi && m_cfg[k][0]; b0 = gt0 && m_cfg[k][1]; b1 = gt1 && m_cfg[k][1];
          t_inv[k] = gi ? "R3" : "R5"; t_trc[k] = "R3";
        end
        e_inv[k] = a; e_trc0[k] = b0; e_trc1[k] = b1;
      end
      e_err = wv && !(ws && wp);
      if (wv && ws && wp) m_cfg[wc] = wd;
    end
    started = 1'b1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, phase, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      for (int k = 0; k < NC; k++) begin
        chk({t_inv[k], " inv core"}, int'(inv0[k]), int'(e_inv[k]));
        chk({t_trc[k], " trc core"}, int'(trc0[k]), int'(e_trc0[k]));
        chk({t_inv[k], " inv legacy"}, int'(inv1[k]), int'(e_inv[k]));
        chk({"R6 ", t_trc[k], " trc legacy"}, int'(trc1[k]), int'(e_trc1[k]));
      end
      chk("R8 err", int'(err0), int'(e_err));
      chk("R8 err legacy", int'(err1), int'(e_err));
      chk("R4 readback", int'(rd0), int'(m_cfg[rc]));
      chk("R4 readback legacy", int'(rd1), int'(m_cfg[rc]));
    end
  end

  task automatic step(input int n);
    for (int j = 0; j < n; j++) begin
      @(posedge clk);
      #1;
      wv = 1'b0;
    end
  endtask

  task automatic write(input int core, input logic [1:0] d, input logic s, input logic p);
    wc = IW'(core); wd = d; ws = s; wp = p; wv = 1'b1;
    @(posedge clk);
    #1;
    wv = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R10: reset state, registers zero and outputs low
    sec = '1; prv = '1; ginv = '1; gtrc = '1; spi = '1; spt = '1;
    #1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    step(1);
    // R7: full normal-world debug while all secure enables are off
    phase = "R7";
    sec = '0; prv = 4'b0101; ginv = '1; gtrc = '1; spi = '0; spt = '0;
    step(3);
    // R1 R2: secure privileged denied, then allowed per input
    phase = "R1";
    sec = '1; prv = '1;
    step(2);
    spi = 4'b1010; spt = 4'b0110;
    step(2);
    // R5: global halting enable low blocks halting everywhere
    phase = "R5";
    ginv = '0;
    step(2);
    sec = '0;
    step(2);
    ginv = '1;
    // R8 R4: rejected writes from normal world and from user mode
    phase = "R8";
    sec = '1; prv = '0;
    write(2, 2'b11, 1'b0, 1'b1);
    write(2, 2'b11, 1'b1, 1'b0);
    rc = 2'd2;
    step(2);
    // R3: accepted write gives secure user halting only
    phase = "R3";
    write(2, 2'b01, 1'b1, 1'b1);
    step(2);
    write(1, 2'b10, 1'b1, 1'b1);
    rc = 2'd1;
    gtrc = 4'b1101;
    step(2);
    // R9: one core's enables do not reach the others
    phase = "R9";
    sec = '0; ginv = 4'b1110; gtrc = 4'b0111;
    step(3);
    // mixed stimulus
    phase = "mixed";
    for (int n = 0; n < 4000; n++) begin
      sec  = NC'($urandom); prv = NC'($urandom);
      ginv = NC'($urandom | $urandom); gtrc = NC'($urandom | $urandom);
      spi  = NC'($urandom); spt = NC'($urandom);
      rc   = IW'($urandom);
      if ($urandom_range(0, 2) == 0) begin
        wc = IW'($urandom); wd = 2'($urandom);
        ws = 1'($urandom); wp = 1'($urandom); wv = 1'b1;
        @(posedge clk);
        #1;
        wv = 1'b0;
      end else begin
        step(1);
      end
    end
    step(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule